// File: doc/BRIEF.md
# External Bus Cycle Controller with Address-Phase Float

This block runs the external bus cycles of a 16-bit core. Each cycle walks through four clock phases, T1 to T4. A dedicated 20-bit address output is loaded at the start of T1 and holds the address for the whole cycle. A shared address/data bus is also provided. In classic multiplexed operation, this shared bus carries the low address half during the second half of T1. After that it carries write data, or it floats so that read data can be sampled.

The core tags each request with the memory region it targets. Two configuration inputs, one per region, can remove the address from the shared bus for that region. In that case the shared bus floats through the address phase and carries data only. A strap input is captured on the first clock after reset is released. When it is low, the region bits are overridden and every cycle is multiplexed until the next reset.

The strobes are active low. There is one read strobe, which doubles as an output enable, and two byte write strobes. The high byte strobe is gated by the core's byte-high enable and the low byte strobe by address bit 0.

Top module: `bus_cycle_ctrl`

## Requirements
- R1: After reset all strobes are high, the shared bus is not driven, done_o is low and req_ready_o is high.
- R2: An accepted request runs exactly T1, T2, T3, T4. req_ready_o is high only in idle and in T4 (so cycles may run back to back) and is low in T1–T3.
- R3: addr_o takes the request address at the clock edge that starts T1 and holds it unchanged through T4.
- R4: The shared bus is never driven in the first half of T1, so addr_o leads the address on the shared bus by half a clock. When the address is shown there, ad_o equals address bits 15:0 with ad_oe_o high from the falling edge inside T1 until T1 ends.
- R5: Region tag 2'b01 selects the lower region and 2'b10 the upper region. When the selected region's disable input is 1 (and no override applies), ad_oe_o stays low for all of T1.
- R6: A strap sampled low on the first rising edge after reset release forces the address onto the shared bus for every cycle, whatever the disable inputs. The captured value is kept until the next reset, even if the strap pin changes.
- R7: A region tag of 2'b00 or 2'b11 always puts the address on the shared bus in T1.
- R8: whb_no is low only in T2–T3 of a write whose req_bhe_ni is 0.
- R9: wlb_no is low only in T2–T3 of a write whose address bit 0 is 0.
- R10: On a read, rd_no is low in T2–T3 only. The block leaves the shared bus undriven in T2–T4. ad_i is captured at the end of T3 into rd_data_o, and done_o is high during T4.
- R11: On a write, ad_o carries the write data with ad_oe_o high through T2–T4, done_o is high in T4, and rd_no stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strap_mux_ni | input | 1 | Strap; low at the first edge after reset forces multiplexed addressing |
| adis_lower_i | input | 1 | Address disable for the lower region |
| adis_upper_i | input | 1 | Address disable for the upper region |
| req_i | input | 1 | Bus cycle request |
| req_addr_i | input | 20 | Request address |
| req_wdata_i | input | 16 | Write data |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_bhe_ni | input | 1 | Byte-high enable, active low |
| req_region_i | input | 2 | Region tag (01 lower, 10 upper, others none) |
| req_ready_o | output | 1 | A request is accepted at the next rising edge |
| ad_i | input | 16 | Shared bus input |
| ad_o | output | 16 | Shared bus output value |
| ad_oe_o | output | 1 | Shared bus output enable |
| addr_o | output | 20 | Dedicated address bus |
| rd_no | output | 1 | Read strobe / output enable, active low |
| whb_no | output | 1 | High byte write strobe, active low |
| wlb_no | output | 1 | Low byte write strobe, active low |
| rd_data_o | output | 16 | Captured read data |
| done_o | output | 1 | High during T4 |

## Verification
The assertions assume that request fields change only while req_ready_o is high or req_i is low. They also assume that the strap and disable inputs are settled when a request is accepted, and that ad_i is valid before the end of T3 on reads. The driver changes every input only at falling edges. It raises a request only after seeing req_ready_o high, and it places read data on ad_i at the middle of T2. It also keeps the strap steady through the reset release and the first edge after it, and changes the strap only once that capture edge has passed.

// File: rtl/bcc_pkg.sv
package bcc_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_T3   = 3'd3,
    PH_T4   = 3'd4
  } phase_e;

  localparam int REGION_W = 2;
  localparam logic [REGION_W-1:0] RGN_LOWER = 2'b01;
  localparam logic [REGION_W-1:0] RGN_UPPER = 2'b10;
endpackage

// File: rtl/bcc_phase_seq.sv
module bcc_phase_seq
  import bcc_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   req_i,
  output phase_e phase_o,
  output logic   ready_o,
  output logic   accept_o
);
  phase_e phase_q, phase_d;

  assign ready_o  = (phase_q == PH_IDLE) || (phase_q == PH_T4);
  assign accept_o = ready_o && req_i;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE: if (req_i) phase_d = PH_T1;
      PH_T1:   phase_d = PH_T2;
      PH_T2:   phase_d = PH_T3;
      PH_T3:   phase_d = PH_T4;
      PH_T4:   phase_d = req_i ? PH_T1 : PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_IDLE;
    else         phase_q <= phase_d;
  end

  assign phase_o = phase_q;

  p_t1_to_t2_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q == PH_T1 |=> phase_q == PH_T2);
  p_t2_to_t3_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q == PH_T2 |=> phase_q == PH_T3);
  p_t3_to_t4_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q == PH_T3 |=> phase_q == PH_T4);
endmodule

// File: rtl/bcc_strap_cfg.sv
module bcc_strap_cfg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strap_mux_ni,
  output logic force_mux_o
);
  logic first_q;
  logic force_q;

  // strap taken on the first rising edge after reset release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q <= 1'b1;
      force_q <= 1'b1;
    end else if (first_q) begin
      first_q <= 1'b0;
      force_q <= ~strap_mux_ni;
    end
  end

  assign force_mux_o = force_q;

  p_strap_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !first_q |=> $stable(force_mux_o));
endmodule

// File: rtl/bcc_strobe_gen.sv
module bcc_strobe_gen
  import bcc_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  phase_e phase_i,
  input  logic   write_i,
  input  logic   bhe_ni,
  input  logic   a0_i,
  output logic   rd_no,
  output logic   whb_no,
  output logic   wlb_no
);
  logic strobe_win;
  logic wr_act;

  assign strobe_win = (phase_i == PH_T2) || (phase_i == PH_T3);
  assign wr_act     = strobe_win && write_i;

  assign rd_no  = ~(strobe_win && !write_i);
  assign whb_no = ~(wr_act && !bhe_ni);
  assign wlb_no = ~(wr_act && !a0_i);

  p_rw_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_no |-> (whb_no && wlb_no));
  p_quiet_outside_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_IDLE || phase_i == PH_T1 || phase_i == PH_T4)
      |-> (rd_no && whb_no && wlb_no));
endmodule

// File: rtl/bcc_bus_drive.sv
module bcc_bus_drive
  import bcc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  phase_e            phase_i,
  input  logic              addr_on_ad_i,
  input  logic              write_i,
  input  logic [DATA_W-1:0] addr_lo_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] ad_i,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o
);
  logic half_q;
  logic addr_win;
  logic data_win;
  logic [DATA_W-1:0] rdata_q;

  // second half of T1 only: address lags the dedicated bus by half a clock
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) half_q <= 1'b0;
    else         half_q <= (phase_i == PH_T1);
  end

  assign addr_win = (phase_i == PH_T1) && half_q && addr_on_ad_i;
  assign data_win = write_i &&
                    (phase_i == PH_T2 || phase_i == PH_T3 || phase_i == PH_T4);

  assign ad_oe_o = addr_win || data_win;
  assign ad_o    = addr_win ? addr_lo_i : wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          rdata_q <= '0;
    else if (phase_i == PH_T3 && !write_i) rdata_q <= ad_i;
  end

  assign rdata_o = rdata_q;
  assign done_o  = (phase_i == PH_T4);

  p_read_float_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!write_i && (phase_i == PH_T2 || phase_i == PH_T3 || phase_i == PH_T4))
      |-> !ad_oe_o);
  p_t1_float_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_T1 && !addr_on_ad_i) |-> !ad_oe_o);
  p_idle_float_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_i == PH_IDLE |-> !ad_oe_o);
endmodule

// File: rtl/bus_cycle_ctrl.sv
module bus_cycle_ctrl
  import bcc_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strap_mux_ni,
  input  logic              adis_lower_i,
  input  logic              adis_upper_i,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              req_write_i,
  input  logic              req_bhe_ni,
  input  logic [1:0]        req_region_i,
  output logic              req_ready_o,
  input  logic [DATA_W-1:0] ad_i,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              rd_no,
  output logic              whb_no,
  output logic              wlb_no,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              done_o
);
  localparam int LO_W = (DATA_W < ADDR_W) ? DATA_W : ADDR_W;

  phase_e phase;
  logic   accept;
  logic   force_mux;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              write_q;
  logic              bhe_nq;
  logic              addr_on_ad_q;
  logic              region_adis;
  logic [DATA_W-1:0] addr_lo;

  bcc_phase_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .phase_o  (phase),
    .ready_o  (req_ready_o),
    .accept_o (accept)
  );

  bcc_strap_cfg u_strap (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .strap_mux_ni (strap_mux_ni),
    .force_mux_o  (force_mux)
  );

  always_comb begin
    unique case (req_region_i)
      RGN_LOWER: region_adis = adis_lower_i;
      RGN_UPPER: region_adis = adis_upper_i;
      default:   region_adis = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q       <= '0;
      wdata_q      <= '0;
      write_q      <= 1'b0;
      bhe_nq       <= 1'b1;
      addr_on_ad_q <= 1'b1;
    end else if (accept) begin
      addr_q       <= req_addr_i;
      wdata_q      <= req_wdata_i;
      write_q      <= req_write_i;
      bhe_nq       <= req_bhe_ni;
      addr_on_ad_q <= force_mux || !region_adis;
    end
  end

  always_comb begin
    addr_lo = '0;
    addr_lo[LO_W-1:0] = addr_q[LO_W-1:0];
  end

  assign addr_o = addr_q;

  bcc_strobe_gen u_strobe (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .phase_i (phase),
    .write_i (write_q),
    .bhe_ni  (bhe_nq),
    .a0_i    (addr_q[0]),
    .rd_no   (rd_no),
    .whb_no  (whb_no),
    .wlb_no  (wlb_no)
  );

  bcc_bus_drive #(.DATA_W(DATA_W)) u_drive (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .phase_i      (phase),
    .addr_on_ad_i (addr_on_ad_q),
    .write_i      (write_q),
    .addr_lo_i    (addr_lo),
    .wdata_i      (wdata_q),
    .ad_i         (ad_i),
    .ad_o         (ad_o),
    .ad_oe_o      (ad_oe_o),
    .rdata_o      (rd_data_o),
    .done_o       (done_o)
  );

  p_addr_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_T2 || phase == PH_T3 || phase == PH_T4) |-> $stable(addr_o));
  p_ready_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_T1 || phase == PH_T2 || phase == PH_T3) |-> !req_ready_o);
endmodule

// File: tb/bus_cycle_ctrl_tb_top.sv
`timescale 1ns/1ps
module bus_cycle_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap_n = 1'b1;
  logic        adis_lo = 1'b0, adis_up = 1'b0;
  logic        req = 1'b0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_write = 1'b0, req_bhe_n = 1'b1;
  logic [1:0]  req_region = 2'b00;
  logic        req_ready;
  logic [15:0] ad_in = '0;
  logic [15:0] ad_out;
  logic        ad_oe;
  logic [19:0] addr;
  logic        rd_n, whb_n, wlb_n, done;
  logic [15:0] rd_data;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic        write;
    logic [19:0] addr;
    logic [15:0] data;
  } exp_t;
  exp_t sb_q[$];

  always #2.5 clk = ~clk;

  bus_cycle_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .strap_mux_ni(strap_n),
    .adis_lower_i(adis_lo), .adis_upper_i(adis_up),
    .req_i(req), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .req_write_i(req_write), .req_bhe_ni(req_bhe_n), .req_region_i(req_region),
    .req_ready_o(req_ready), .ad_i(ad_in), .ad_o(ad_out), .ad_oe_o(ad_oe),
    .addr_o(addr), .rd_no(rd_n), .whb_no(whb_n), .wlb_no(wlb_n),
    .rd_data_o(rd_data), .done_o(done)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per completed cycle
  always @(negedge clk) begin
    if (rst_n && done) begin
      #1;
      if (sb_q.size() == 0) chk(1'b0, "R2 unexpected done", 32'd1, 32'd0);
      else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(addr == e.addr, "R3 addr at done", addr, e.addr);
        if (e.write)
          chk(ad_oe && ad_out == e.data && rd_n, "R11 write data T4",
              {15'd0, ad_oe, ad_out}, {16'd1, e.data});
        else
          chk(rd_data == e.data && !ad_oe, "R10 read data", rd_data, e.data);
      end
    end
  end

  task automatic do_reset(input logic strap);
    rst_n = 1'b0;
    strap_n = strap;
    repeat (3) @(negedge clk);
    #1;
    chk(rd_n && whb_n && wlb_n && !ad_oe && !done && req_ready, "R1 reset state",
        {27'd0, rd_n, whb_n, wlb_n, ad_oe, done}, 32'h1c);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bus_cycle(input logic wr, input logic [19:0] a,
                           input logic [15:0] d, input logic bhe_n,
                           input logic [1:0] rgn, input logic exp_addr_on_ad);
    exp_t e;
    logic exp_whb, exp_wlb;
    exp_whb = !(wr && !bhe_n);
    exp_wlb = !(wr && !a[0]);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req = 1'b1; req_addr = a; req_wdata = d; req_write = wr;
    req_bhe_n = bhe_n; req_region = rgn;
    e.write = wr; e.addr = a; e.data = d;
    sb_q.push_back(e);
    @(posedge clk); #1;
    chk(addr == a, "R3 addr at T1 start", addr, a);
    chk(!ad_oe, "R4 no drive first half T1", ad_oe, 1'b0);
    chk(!req_ready, "R2 busy in T1", req_ready, 1'b0);
    @(negedge clk); #1;
    req = 1'b0;
    chk(ad_oe == exp_addr_on_ad, "R5/R6/R7 address on shared bus", ad_oe, exp_addr_on_ad);
    if (exp_addr_on_ad) chk(ad_out == a[15:0], "R4 shared bus address", ad_out, a[15:0]);
    @(negedge clk); #1;
    if (!wr) ad_in = d;
    chk(rd_n == wr, "R10 read strobe T2", rd_n, wr);
    chk(whb_n == exp_whb, "R8 whb T2", whb_n, exp_whb);
    chk(wlb_n == exp_wlb, "R9 wlb T2", wlb_n, exp_wlb);
    chk(ad_oe == wr, "R10/R11 bus drive T2", ad_oe, wr);
    @(negedge clk); #1;
    chk(rd_n == wr && whb_n == exp_whb && wlb_n == exp_wlb, "R8/R9/R10 strobes T3",
        {rd_n, whb_n, wlb_n}, {wr, exp_whb, exp_wlb});
    chk(addr == a, "R3 addr held T3", addr, a);
    @(negedge clk); #1;
    chk(rd_n && whb_n && wlb_n, "R8/R9/R10 strobes off T4", {rd_n, whb_n, wlb_n}, 3'b111);
    chk(done && req_ready, "R2 done and ready in T4", {done, req_ready}, 2'b11);
    ad_in = 16'h0;
  endtask

  initial begin
    #100000;
    chk(1'b0, "watchdog expired", 32'd0, 32'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    do_reset(1'b1);
    adis_lo = 1'b1; adis_up = 1'b0;
    bus_cycle(1'b1, 20'hA1234, 16'hBEEF, 1'b0, 2'b01, 1'b0); // R5 lower floated
    bus_cycle(1'b0, 20'h5ABC1, 16'h1357, 1'b0, 2'b10, 1'b1); // upper shown
    adis_up = 1'b1;
    bus_cycle(1'b0, 20'h5ABC2, 16'h2468, 1'b0, 2'b10, 1'b0); // R5 upper floated
    bus_cycle(1'b1, 20'h00003, 16'hC0DE, 1'b0, 2'b00, 1'b1); // R7 none
    bus_cycle(1'b1, 20'h7FFF0, 16'h4242, 1'b1, 2'b11, 1'b1); // R7, R9 low only
    bus_cycle(1'b1, 20'h12345, 16'h9999, 1'b0, 2'b01, 1'b0); // R8 high only
    // strap forcing multiplexed mode
    do_reset(1'b0);
    strap_n = 1'b1;
    bus_cycle(1'b1, 20'h0BEEF, 16'h7777, 1'b0, 2'b01, 1'b1); // R6
    bus_cycle(1'b0, 20'hFEDCB, 16'hA5A5, 1'b0, 2'b10, 1'b1); // R6 held
    repeat (4) @(negedge clk);
    chk(sb_q.size() == 0, "R2 all cycles completed", sb_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule